// File: doc/BRIEF.md
# Virtual Device Interrupt Status Controller

This block sits between a host processor's I/O command path and a slow, polled software agent that emulates a peripheral. It keeps the state the host sees for one emulated device. That state is a stored device status word (DSW), a locally held Operation Complete flag, and three interrupt-level pending bits. The pending bits drive the interrupt request lines directly.

A host Sense Device command is answered in the same cycle. When the command carries reset modifier bits, the selected pending bits and the Operation Complete flag are cleared in hardware. The interrupt request therefore drops before the host runs its next instruction, and later senses read Operation Complete as zero.

The agent writes DSW updates and can raise a pending bit at any time. It also issues a fetch-and-clear transaction, code 13. This transaction returns the current pending bits and clears them, so the agent's shadow copy of the device state can catch up with resets it did not see.

Top module: `vdisc_top`

## Requirements
- R1: After reset, `irqOut`, `hostSenseData` and `agentRdData` are all zero.
- R2: An agent transaction with code 4 stores `agentTxnData`. From the next cycle on, every DSW bit except bit 3 is returned on `hostSenseData` while `hostSense` is high. `hostSenseData` is zero while `hostSense` is low.
- R3: A code-4 write with bit 3 (Operation Complete) set does two things. It sets the local Operation Complete flag, which appears as bit 3 of the sense data. It also sets pending bit `agentTxnLvl` (0 to 2; the value 3 selects none). The matching `irqOut` bit is high from the next cycle.
- R4: A sense with a nonzero `hostRstMask` clears each pending bit whose mask bit is 1, and the request is low in the next cycle. Pending bits whose mask bit is 0 are kept.
- R5: A sense with a nonzero `hostRstMask` clears the Operation Complete flag. Later senses read bit 3 as 0, even though the stored DSW still has bit 3 set.
- R6: A code-4 write with bit 3 clear leaves the Operation Complete flag and the pending bits unchanged.
- R7: Code 13 presents the current pending bits on `agentRdData` in the same cycle and clears all of them at the clock edge. `agentRdData` is zero when no code-13 transaction is present.
- R8: If a sense-with-reset and a code-13 fetch fall in one cycle, the fetch returns the bits as they were before the clear, and all bits end cleared.
- R9: If a code-4 write with bit 3 set and a sense-with-reset fall in one cycle, the set wins, for both the flag and the selected pending bit.
- R10: Synchronous reset `rst` clears the stored DSW, the flag and all pending bits.
- R11: Transaction codes other than 4 and 13 change nothing. A sense with an all-zero mask changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| agentTxnValid | input | 1 | Agent transaction present this cycle |
| agentTxnCode | input | 4 | Transaction code (4 = DSW write, 13 = fetch-and-clear) |
| agentTxnData | input | 16 | DSW value for a code-4 write |
| agentTxnLvl | input | 2 | Interrupt level raised by an Operation Complete write (3 = none) |
| agentRdData | output | 3 | Pending bits returned by a code-13 fetch |
| hostSense | input | 1 | Host Sense Device command this cycle |
| hostRstMask | input | 3 | Reset modifier bits, one per interrupt level |
| hostSenseData | output | 16 | DSW returned to the host |
| irqOut | output | 3 | Interrupt requests, one per level |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a host sense-with-reset and an agent fetch-and-clear. The second is a sense-with-reset and an agent Operation Complete write that targets the same pending bit. The bench drives each pair together in one cycle. It checks the fetched value against the pre-clear state, and checks the following cycle for cleared bits, or for the set surviving. A behavioural model runs alongside and judges every cycle. That includes the sense data read in the same cycle as its own reset, which must still show the old Operation Complete value.

// File: rtl/vdisc_pkg.sv
package vdisc_pkg;
  localparam int LVL_N = 3;
  localparam int LVL_IDX_W = $clog2(LVL_N + 1);
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_DSW_WR = 4'd4;
  localparam logic [CODE_W-1:0] CODE_FETCH = 4'd13;

  typedef struct packed {
    logic dswLoad;
    logic opcSet;
    logic opcClr;
    logic [LVL_N-1:0] lvlSet;
    logic [LVL_N-1:0] lvlClr;
    logic fetchRd;
    logic senseRd;
  } vdisc_strobe_t;
endpackage

// File: rtl/vdisc_ctrl.sv
module vdisc_ctrl
  import vdisc_pkg::*;
#(
  parameter int DSW_W = 16,
  parameter int OPC_POS = 3
) (
  input  logic                      agentTxnValid,
  input  logic [CODE_W-1:0]         agentTxnCode,
  input  logic [DSW_W-1:0]          agentTxnData,
  input  logic [LVL_IDX_W-1:0]      agentTxnLvl,
  input  logic                      hostSense,
  input  logic [LVL_N-1:0]          hostRstMask,
  output vdisc_strobe_t             strobe
);
  logic isWrite;
  logic isFetch;
  logic senseReset;

  always_comb begin
    isWrite = agentTxnValid && (agentTxnCode == CODE_DSW_WR);
    isFetch = agentTxnValid && (agentTxnCode == CODE_FETCH);
    senseReset = hostSense && (|hostRstMask);

    strobe = '0;
    strobe.dswLoad = isWrite;
    strobe.opcSet = isWrite && agentTxnData[OPC_POS];
    strobe.opcClr = senseReset;
    strobe.fetchRd = isFetch;
    strobe.senseRd = hostSense;
    for (int i = 0; i < LVL_N; i++) begin
      strobe.lvlSet[i] = isWrite && agentTxnData[OPC_POS] &&
                         (agentTxnLvl == LVL_IDX_W'(i));
      strobe.lvlClr[i] = isFetch || (senseReset && hostRstMask[i]);
    end
  end
endmodule

// File: rtl/vdisc_datapath.sv
module vdisc_datapath
  import vdisc_pkg::*;
#(
  parameter int DSW_W = 16,
  parameter int OPC_POS = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  vdisc_strobe_t      strobe,
  input  logic [DSW_W-1:0]   dswIn,
  output logic [DSW_W-1:0]   senseData,
  output logic [LVL_N-1:0]   fetchData,
  output logic [LVL_N-1:0]   irqOut
);
  logic [DSW_W-1:0] dswQ;
  logic [LVL_N-1:0] lvlQ;
  logic opcQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      dswQ <= '0;
      lvlQ <= '0;
      opcQ <= 1'b0;
    end else begin
      if (strobe.dswLoad) dswQ <= dswIn;
      lvlQ <= (lvlQ & ~strobe.lvlClr) | strobe.lvlSet;
      if (strobe.opcSet) opcQ <= 1'b1;
      else if (strobe.opcClr) opcQ <= 1'b0;
    end
  end

  always_comb begin
    senseData = '0;
    if (strobe.senseRd) begin
      senseData = dswQ;
      senseData[OPC_POS] = opcQ;
    end
    fetchData = strobe.fetchRd ? lvlQ : '0;
    irqOut = lvlQ;
  end
endmodule

// File: rtl/vdisc_top.sv
module vdisc_top
  import vdisc_pkg::*;
#(
  parameter int DSW_W = 16,
  parameter int OPC_POS = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  agentTxnValid,
  input  logic [CODE_W-1:0]     agentTxnCode,
  input  logic [DSW_W-1:0]      agentTxnData,
  input  logic [LVL_IDX_W-1:0]  agentTxnLvl,
  output logic [LVL_N-1:0]      agentRdData,
  input  logic                  hostSense,
  input  logic [LVL_N-1:0]      hostRstMask,
  output logic [DSW_W-1:0]      hostSenseData,
  output logic [LVL_N-1:0]      irqOut
);
  vdisc_strobe_t strobe;

  vdisc_ctrl #(.DSW_W(DSW_W), .OPC_POS(OPC_POS)) u_ctrl (
    .agentTxnValid(agentTxnValid),
    .agentTxnCode(agentTxnCode),
    .agentTxnData(agentTxnData),
    .agentTxnLvl(agentTxnLvl),
    .hostSense(hostSense),
    .hostRstMask(hostRstMask),
    .strobe(strobe)
  );

  vdisc_datapath #(.DSW_W(DSW_W), .OPC_POS(OPC_POS)) u_dp (
    .clk(clk),
    .rst(rst),
    .strobe(strobe),
    .dswIn(agentTxnData),
    .senseData(hostSenseData),
    .fetchData(agentRdData),
    .irqOut(irqOut)
  );
endmodule

// File: rtl/vdisc_chk.sv
module vdisc_chk
  import vdisc_pkg::*;
#(
  parameter int DSW_W = 16,
  parameter int OPC_POS = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  agentTxnValid,
  input logic [CODE_W-1:0]     agentTxnCode,
  input logic [DSW_W-1:0]      agentTxnData,
  input logic [LVL_IDX_W-1:0]  agentTxnLvl,
  input logic [LVL_N-1:0]      agentRdData,
  input logic                  hostSense,
  input logic [LVL_N-1:0]      hostRstMask,
  input logic [DSW_W-1:0]      hostSenseData,
  input logic [LVL_N-1:0]      irqOut
);
  logic wrOpc;
  logic fetchOp;
  logic otherCode;
  assign wrOpc = agentTxnValid && agentTxnCode == CODE_DSW_WR && agentTxnData[OPC_POS];
  assign fetchOp = agentTxnValid && agentTxnCode == CODE_FETCH;
  assign otherCode = agentTxnValid && agentTxnCode != CODE_DSW_WR && agentTxnCode != CODE_FETCH;

  // R1 R10
  reset_clears_chk: assert property (@(posedge clk) rst |=> (irqOut == '0));

  // R3
  opc_raises_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (wrOpc && agentTxnLvl < LVL_IDX_W'(LVL_N)) |=> ((irqOut & (LVL_N'(1) << $past(agentTxnLvl))) != '0));

  // R4
  sense_rst_drops_chk: assert property (@(posedge clk) disable iff (rst)
    (hostSense && (|hostRstMask) && !wrOpc) |=> ((irqOut & $past(hostRstMask)) == '0));

  // R5
  opc_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (hostSense && (|hostRstMask) && !wrOpc) |=> (!hostSense || !hostSenseData[OPC_POS]));

  // R7
  fetch_returns_chk: assert property (@(posedge clk) disable iff (rst)
    fetchOp |-> (agentRdData == irqOut));

  // R7 R8
  fetch_clears_chk: assert property (@(posedge clk) disable iff (rst)
    fetchOp |=> (irqOut == '0));

  // R11
  other_code_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (otherCode && !hostSense) |=> $stable(irqOut));
endmodule

bind vdisc_top vdisc_chk #(.DSW_W(DSW_W), .OPC_POS(OPC_POS)) u_chk (.*);

// File: tb/sim_vdisc_top.sv
module sim_vdisc_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic agentTxnValid = 1'b0;
  logic [3:0] agentTxnCode = '0;
  logic [15:0] agentTxnData = '0;
  logic [1:0] agentTxnLvl = 2'd3;
  logic [2:0] agentRdData;
  logic hostSense = 1'b0;
  logic [2:0] hostRstMask = '0;
  logic [15:0] hostSenseData;
  logic [2:0] irqOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  bit [15:0] mDsw;
  bit [2:0] mLvl;
  bit mOpc;

  always #4 clk = ~clk;

  vdisc_top u0 (.*);

  task automatic drive(input bit r, input bit v, input int code, input int data,
                       input int lvl, input bit s, input int mask);
    rst = r; agentTxnValid = v; agentTxnCode = 4'(code); agentTxnData = 16'(data);
    agentTxnLvl = 2'(lvl); hostSense = s; hostRstMask = 3'(mask);
  endtask

  task automatic step(input string tag, input bit r, input bit v, input int code,
                      input int data, input int lvl, input bit s, input int mask);
    bit [15:0] expSense;
    bit [2:0] expRd;
    bit [2:0] clr;
    bit [2:0] set;
    bit oSet;
    bit oClr;
    @(negedge clk);
    drive(r, v, code, data, lvl, s, mask);
    #1;
    expSense = '0;
    if (s) begin
      expSense = mDsw;
      expSense[3] = mOpc;
    end
    expRd = (v && code == 13) ? mLvl : 3'b000;
    checks++;
    if (irqOut !== mLvl || hostSenseData !== expSense || agentRdData !== expRd) begin
      failures++;
      $display("FAIL %s irq=%b sense=%h rd=%b expected irq=%b sense=%h rd=%b",
               tag, irqOut, hostSenseData, agentRdData, mLvl, expSense, expRd);
    end
    @(posedge clk);
    if (r) begin
      mDsw = '0; mLvl = '0; mOpc = 0;
    end else begin
      clr = '0; set = '0; oSet = 0; oClr = 0;
      if (s && mask != 0) begin
        clr = clr | 3'(mask);
        oClr = 1;
      end
      if (v && code == 13) clr = 3'b111;
      if (v && code == 4) begin
        mDsw = 16'(data);
        if (data[3]) begin
          oSet = 1;
          if (lvl < 3) set[lvl] = 1'b1;
        end
      end
      mLvl = (mLvl & ~clr) | set;
      if (oSet) mOpc = 1;
      else if (oClr) mOpc = 0;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step("R10 reset", 1, 0, 0, 0, 3, 0, 0);
    step("R1 idle after reset", 0, 0, 0, 0, 3, 1, 0);
    step("R2 write plain", 0, 1, 4, 'h1230, 3, 0, 0);
    step("R2 sense plain", 0, 0, 0, 0, 3, 1, 0);
    step("R2 no sense zero", 0, 0, 0, 0, 3, 0, 0);
    step("R3 write opc lvl1", 0, 1, 4, 'hA5A8, 1, 0, 0);
    step("R3 sense opc set", 0, 0, 0, 0, 3, 1, 0);
    step("R5 sense reset lvl0", 0, 0, 0, 0, 3, 1, 1);
    step("R4 R5 lvl1 kept opc zero", 0, 0, 0, 0, 3, 1, 0);
    step("R4 sense reset lvl1", 0, 0, 0, 0, 3, 1, 2);
    step("R4 irq dropped", 0, 0, 0, 0, 3, 0, 0);
    step("R3 write opc lvl2", 0, 1, 4, 'h0008, 2, 0, 0);
    step("R6 write no opc", 0, 1, 4, 'h7F70, 0, 0, 0);
    step("R6 flag held", 0, 0, 0, 0, 3, 1, 0);
    step("R3 write opc lvl0", 0, 1, 4, 'h0008, 0, 0, 0);
    step("R7 fetch", 0, 1, 13, 0, 3, 0, 0);
    step("R7 fetch empty", 0, 1, 13, 0, 3, 0, 0);
    step("R3 write opc lvl1", 0, 1, 4, 'h0009, 1, 0, 0);
    step("R3 write opc lvl2", 0, 1, 4, 'h0009, 2, 0, 0);
    step("R8 fetch with sense reset", 0, 1, 13, 0, 3, 1, 2);
    step("R8 all cleared", 0, 0, 0, 0, 3, 1, 0);
    step("R9 write opc and reset", 0, 1, 4, 'h0108, 0, 1, 7);
    step("R9 set wins", 0, 0, 0, 0, 3, 1, 0);
    step("R11 other code", 0, 1, 9, 'hFFFF, 1, 0, 0);
    step("R11 zero mask sense", 0, 0, 0, 0, 3, 1, 0);
    step("R11 state kept", 0, 0, 0, 0, 3, 1, 0);
    step("R3 write opc lvl2", 0, 1, 4, 'hBEEF, 2, 0, 0);
    step("R10 mid reset", 1, 0, 0, 0, 3, 1, 0);
    step("R10 after reset", 0, 0, 0, 0, 3, 1, 0);
    step("R7 fetch after reset", 0, 1, 13, 0, 3, 0, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule